// File: doc/BRIEF.md
# PC-Style Serial Port Register and Interrupt Unit

This block is the host side of a classic PC serial port. A host reaches eight byte-wide locations through a 3-bit address with separate read and write strobes. The block holds the line-format settings, the modem control bits, the interrupt enables and the 16-bit baud divisor. It assembles the line status, modem status and interrupt identification bytes and drives one interrupt line.

A separate framing engine does the serial work. It takes transmit bytes through a valid/ready pair and returns received bytes as a one-cycle pulse with error flags. It reads the line settings, divisor and loopback request straight from this block's outputs. Four modem input lines come in, and four modem control lines go out.

Read data is combinational from the address. Any clearing side effect of a read happens on the clock edge that ends the read cycle.

Top module: `uart_regs_top`

## Requirements
- R1: With `rst_n` low at a clock edge (synchronous), line control, interrupt enable, modem control and both divisor bytes go to zero. All pending flags clear. Afterwards IIR reads 0x01, LSR reads 0x60 while `tx_idle_i` is high, and `irq_o` is low.
- R2: The address map is: 0 data, 1 interrupt enable, 2 interrupt ID, 3 line control, 4 modem control, 5 line status, 6 modem status. Address 7 reads 0 and ignores writes, as do writes to 2, 5 and 6. Interrupt enable bits 7:4 and modem control bits 7:5 read as zero.
- R3: While line control bit 7 is set, addresses 0 and 1 read and write the divisor low and high bytes. `divisor_o` is {high, low}. The transmit holding byte and the interrupt enable register are left untouched.
- R4: A write to address 0 with bit 7 clear loads `tx_data_o` and raises `tx_valid_o`. The byte stays stable until a cycle with `tx_ready_i` high. LSR bit 5 is set while the holding byte is empty. LSR bit 6 is set while it is empty and `tx_idle_i` is high.
- R5: A `rx_valid_i` pulse stores `rx_data_i` and sets LSR bit 0. A data read at address 0 clears bit 0. A pulse that arrives while bit 0 is set, and is not in a data-read cycle, sets overrun (bit 1). Parity, framing and break flags latch into bits 2, 3 and 4. An LSR read clears bits 1 to 4, unless one is set again in the same cycle.
- R6: IIR bit 0 is 0 while any enabled cause is pending, otherwise 1. Bits 2:1 give the top pending cause: 11 line error (enable bit 2), 10 data received (enable bit 0), 01 transmit holding empty (enable bit 1), 00 modem status change (enable bit 3). Bits 7:3 read zero.
- R7: The transmit-empty cause is set when the engine takes the holding byte. An IIR read that reports code 01 clears it, and so does a data write. A data write in the same cycle wins over the set.
- R8: With modem control bit 4 clear, bits 0, 1, 2 and 3 drive `dtr_o`, `rts_o`, `out1_o` and `out2_o`.
- R9: MSR bits 4, 5, 6 and 7 show the CTS, DSR, RI and DCD levels, one cycle after the line changes. Bits 0 to 3 are change flags for the same lines. They are set on any level change and cleared by an MSR read; a change in the same cycle as the read wins.
- R10: With modem control bit 4 set, all four modem outputs are 0. The status levels come internally: CTS from RTS, DSR from DTR, RI from OUT1 and DCD from OUT2. `loopback_o` is high.
- R11: `irq_o` is high exactly while modem control bit 3 is set and IIR bit 0 reads 0.
- R12: `line_ctrl_o` presents line control bits 6:0 to the framing engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at clock edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq_o | output | 1 | Gated interrupt request |
| tx_data_o | output | 8 | Holding byte to framing engine |
| tx_valid_o | output | 1 | Holding byte is full |
| tx_ready_i | input | 1 | Engine takes the holding byte |
| tx_idle_i | input | 1 | Engine shifter empty |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | One-cycle received-byte pulse |
| rx_par_err_i | input | 1 | Parity error, qualified by rx_valid_i |
| rx_frm_err_i | input | 1 | Framing error, qualified by rx_valid_i |
| rx_brk_i | input | 1 | Break seen, qualified by rx_valid_i |
| line_ctrl_o | output | 7 | Line format bits to engine |
| divisor_o | output | 16 | Baud divisor |
| loopback_o | output | 1 | Loopback request to engine |
| cts_i | input | 1 | Clear-to-send level |
| dsr_i | input | 1 | Data-set-ready level |
| ri_i | input | 1 | Ring indicator level |
| dcd_i | input | 1 | Carrier detect level |
| dtr_o | output | 1 | Terminal ready |
| rts_o | output | 1 | Request to send |
| out1_o | output | 1 | Auxiliary output 1 |
| out2_o | output | 1 | Auxiliary output 2 |

## Verification
The assertions take for granted that the host never raises read and write strobes in the same cycle. They also assume the error flags from the engine matter only alongside `rx_valid_i`, and that the modem inputs are already synchronised to `clk`. The random stimulus picks at most one of read, write or idle per cycle. It raises error flags only together with a receive pulse, and it flips a modem line only rarely and only between edges. Directed sequences then force the simultaneous cases that random traffic seldom reaches: stacked causes in priority order, overrun, interrupt gating and loopback.

// File: rtl/uart_regs_pkg.sv
// Shared offsets, cause codes and widths for the serial port register unit.
// Assumes a byte-wide host bus and a 3-bit register offset.
package uart_regs_pkg;
    localparam int DW  = 8;
    localparam int AW  = 3;
    localparam int NML = 4;   // modem lines: bit0 cts, bit1 dsr, bit2 ri, bit3 dcd

    typedef enum logic [AW-1:0] {
        OFS_DATA  = 3'd0,
        OFS_IEN   = 3'd1,
        OFS_IID   = 3'd2,
        OFS_LCTL  = 3'd3,
        OFS_MCTL  = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SPARE = 3'd7
    } reg_ofs_e;

    typedef enum logic [1:0] {
        CAUSE_MODEM = 2'b00,
        CAUSE_TXE   = 2'b01,
        CAUSE_RXD   = 2'b10,
        CAUSE_LINE  = 2'b11
    } cause_e;
endpackage

// File: rtl/uart_line_status.sv
// Holding byte toward the framing engine, receive byte, and line status flags.
// Assumes rx error flags are only meaningful together with rx_valid.
module uart_line_status
    import uart_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thr_wr,
    input  logic [DW-1:0] wdata,
    input  logic          rbr_rd,
    input  logic          lsr_rd,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_par_err,
    input  logic          rx_frm_err,
    input  logic          rx_brk,
    input  logic          tx_ready,
    input  logic          tx_idle,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic [DW-1:0] rbr,
    output logic [DW-1:0] lsr,
    output logic          handoff
);
    logic          thr_full_q;
    logic [DW-1:0] thr_q;
    logic [DW-1:0] rbr_q;
    logic          dr_q;
    logic [3:0]    err_q;     // bit0 overrun, bit1 parity, bit2 framing, bit3 break
    logic          oe_set;
    logic [3:0]    err_new;

    assign handoff  = thr_full_q & tx_ready;
    assign tx_valid = thr_full_q;
    assign tx_data  = thr_q;
    assign rbr      = rbr_q;

    // Holding byte: loaded by the host, released when the engine takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_full_q <= 1'b0;
            thr_q      <= '0;
        end else if (thr_wr) begin
            thr_full_q <= 1'b1;
            thr_q      <= wdata;
        end else if (handoff) begin
            thr_full_q <= 1'b0;
        end
    end

    // New error events this cycle, all qualified by the receive pulse.
    always_comb begin
        oe_set  = rx_valid & dr_q & ~rbr_rd;
        err_new = {rx_valid & rx_brk, rx_valid & rx_frm_err, rx_valid & rx_par_err, oe_set};
    end

    // Receive byte, ready flag and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr_q <= '0;
            dr_q  <= 1'b0;
            err_q <= '0;
        end else begin
            if (rx_valid) begin
                rbr_q <= rx_data;
                dr_q  <= 1'b1;
            end else if (rbr_rd) begin
                dr_q  <= 1'b0;
            end
            err_q <= (lsr_rd ? 4'b0000 : err_q) | err_new;
        end
    end

    // Status byte view.
    assign lsr = {1'b0, ~thr_full_q & tx_idle, ~thr_full_q, err_q, dr_q};

    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && dr_q && !rbr_rd) |=> lsr[1]);                          // R5
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_full_q && !tx_ready && !thr_wr) |=> (tx_valid && $stable(tx_data))); // R4
endmodule

// File: rtl/uart_modem_ctrl.sv
// Modem output drive, loopback routing and modem status with change flags.
// Assumes external modem inputs are already synchronised to clk.
module uart_modem_ctrl
    import uart_regs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [4:0]     mcr,
    input  logic           msr_rd,
    input  logic [NML-1:0] ext_lines,   // bit0 cts, bit1 dsr, bit2 ri, bit3 dcd
    output logic           dtr,
    output logic           rts,
    output logic           out1,
    output logic           out2,
    output logic [DW-1:0]  msr
);
    logic           loop;
    logic [NML-1:0] lvl_now;
    logic [NML-1:0] lvl_q;
    logic [NML-1:0] delta_q;

    assign loop = mcr[4];

    // Pick the level source: external pins or internal loopback.
    always_comb begin
        if (loop) lvl_now = {mcr[3], mcr[2], mcr[0], mcr[1]};
        else      lvl_now = ext_lines;
    end

    // Sample levels and accumulate change flags until status is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= lvl_now;
            delta_q <= '0;
        end else begin
            lvl_q   <= lvl_now;
            delta_q <= (msr_rd ? {NML{1'b0}} : delta_q) | (lvl_now ^ lvl_q);
        end
    end

    // Outputs are forced inactive while looped back.
    assign {out2, out1, rts, dtr} = loop ? 4'b0000 : mcr[3:0];
    assign msr = {lvl_q, delta_q};

    AST_DELTA_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_now[0] != lvl_q[0]) |=> delta_q[0]);                         // R9
    AST_DELTA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && (lvl_now == lvl_q)) |=> (delta_q == '0));               // R9
endmodule

// File: rtl/uart_irq_ctrl.sv
// Interrupt cause priority, identification byte and gated interrupt line.
// Assumes cause inputs are registered state from the sibling modules.
module uart_irq_ctrl
    import uart_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    ier,
    input  logic          line_err,
    input  logic          rx_ready,
    input  logic          modem_chg,
    input  logic          handoff,
    input  logic          thr_wr,
    input  logic          iir_rd,
    input  logic          gate,
    output logic [DW-1:0] iir,
    output logic          irq
);
    logic   thre_q;
    logic   pending;
    cause_e cause;
    logic   thre_clr;

    // Prioritise enabled causes: line error, data, transmit empty, modem.
    always_comb begin
        pending = 1'b1;
        cause   = CAUSE_MODEM;
        if (ier[2] && line_err)      cause = CAUSE_LINE;
        else if (ier[0] && rx_ready) cause = CAUSE_RXD;
        else if (ier[1] && thre_q)   cause = CAUSE_TXE;
        else if (ier[3] && modem_chg) cause = CAUSE_MODEM;
        else                          pending = 1'b0;
    end

    assign thre_clr = iir_rd && pending && (cause == CAUSE_TXE);

    // Transmit-empty event: set on handoff, cleared by write or by reporting read.
    always_ff @(posedge clk) begin
        if (!rst_n)        thre_q <= 1'b0;
        else if (thr_wr)   thre_q <= 1'b0;
        else if (handoff)  thre_q <= 1'b1;
        else if (thre_clr) thre_q <= 1'b0;
    end

    assign iir = {5'b00000, cause, ~pending};
    assign irq = gate & pending;

    AST_THRE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_clr && !handoff) |=> !thre_q);                               // R7
endmodule

// File: rtl/uart_regs_top.sv
// Host register file of a PC-style serial port: decode, control registers,
// divisor, read mux. Assumes rd_en and wr_en are never high together.
module uart_regs_top
    import uart_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          irq_o,
    output logic [7:0]    tx_data_o,
    output logic          tx_valid_o,
    input  logic          tx_ready_i,
    input  logic          tx_idle_i,
    input  logic [7:0]    rx_data_i,
    input  logic          rx_valid_i,
    input  logic          rx_par_err_i,
    input  logic          rx_frm_err_i,
    input  logic          rx_brk_i,
    output logic [6:0]    line_ctrl_o,
    output logic [15:0]   divisor_o,
    output logic          loopback_o,
    input  logic          cts_i,
    input  logic          dsr_i,
    input  logic          ri_i,
    input  logic          dcd_i,
    output logic          dtr_o,
    output logic          rts_o,
    output logic          out1_o,
    output logic          out2_o
);
    reg_ofs_e      ofs;
    logic          dlab;
    logic [DW-1:0] lcr_q, dll_q, dlm_q;
    logic [3:0]    ier_q;
    logic [4:0]    mcr_q;
    logic          thr_wr, dll_wr, dlm_wr, ier_wr, lcr_wr, mcr_wr;
    logic          rbr_rd, iir_rd, lsr_rd, msr_rd;
    logic [DW-1:0] rbr, lsr, msr, iir;
    logic          handoff;

    assign ofs  = reg_ofs_e'(addr);
    assign dlab = lcr_q[7];

    // Decode strobes, with the bank bit remapping offsets 0 and 1.
    always_comb begin
        thr_wr = wr_en && (ofs == OFS_DATA) && !dlab;
        dll_wr = wr_en && (ofs == OFS_DATA) &&  dlab;
        ier_wr = wr_en && (ofs == OFS_IEN)  && !dlab;
        dlm_wr = wr_en && (ofs == OFS_IEN)  &&  dlab;
        lcr_wr = wr_en && (ofs == OFS_LCTL);
        mcr_wr = wr_en && (ofs == OFS_MCTL);
        rbr_rd = rd_en && (ofs == OFS_DATA) && !dlab;
        iir_rd = rd_en && (ofs == OFS_IID);
        lsr_rd = rd_en && (ofs == OFS_LSTAT);
        msr_rd = rd_en && (ofs == OFS_MSTAT);
    end

    // Control registers and divisor latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q <= '0;
            ier_q <= '0;
            mcr_q <= '0;
            dll_q <= '0;
            dlm_q <= '0;
        end else begin
            if (lcr_wr) lcr_q <= wdata;
            if (ier_wr) ier_q <= wdata[3:0];
            if (mcr_wr) mcr_q <= wdata[4:0];
            if (dll_wr) dll_q <= wdata;
            if (dlm_wr) dlm_q <= wdata;
        end
    end

    uart_line_status u_line (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .wdata(wdata),
        .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .rx_valid(rx_valid_i), .rx_data(rx_data_i),
        .rx_par_err(rx_par_err_i), .rx_frm_err(rx_frm_err_i), .rx_brk(rx_brk_i),
        .tx_ready(tx_ready_i), .tx_idle(tx_idle_i), .tx_valid(tx_valid_o),
        .tx_data(tx_data_o), .rbr(rbr), .lsr(lsr), .handoff(handoff)
    );

    uart_modem_ctrl u_modem (
        .clk(clk), .rst_n(rst_n), .mcr(mcr_q), .msr_rd(msr_rd),
        .ext_lines({dcd_i, ri_i, dsr_i, cts_i}),
        .dtr(dtr_o), .rts(rts_o), .out1(out1_o), .out2(out2_o), .msr(msr)
    );

    uart_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .ier(ier_q), .line_err(|lsr[4:1]),
        .rx_ready(lsr[0]), .modem_chg(|msr[3:0]), .handoff(handoff),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .gate(mcr_q[3]), .iir(iir), .irq(irq_o)
    );

    // Read data mux.
    always_comb begin
        case (ofs)
            OFS_DATA:  rdata = dlab ? dll_q : rbr;
            OFS_IEN:   rdata = dlab ? dlm_q : {4'b0000, ier_q};
            OFS_IID:   rdata = iir;
            OFS_LCTL:  rdata = lcr_q;
            OFS_MCTL:  rdata = {3'b000, mcr_q};
            OFS_LSTAT: rdata = lsr;
            OFS_MSTAT: rdata = msr;
            default:   rdata = '0;
        endcase
    end

    assign line_ctrl_o = lcr_q[6:0];
    assign divisor_o   = {dlm_q, dll_q};
    assign loopback_o  = mcr_q[4];

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && dlab && (addr[2:1] == 2'b00)) |=> $stable(divisor_o));   // R3
    AST_IER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_wr |=> $stable(ier_q));                                        // R2
endmodule

// File: tb/uart_regs_top_tb.sv
`timescale 1ns/1ps
module uart_regs_top_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic wr_en = 0, rd_en = 0;
    logic [7:0] wdata = '0, rdata;
    logic irq_o, tx_valid_o, loopback_o;
    logic [7:0] tx_data_o;
    logic tx_ready_i = 0, tx_idle_i = 1;
    logic [7:0] rx_data_i = '0;
    logic rx_valid_i = 0, rx_par_err_i = 0, rx_frm_err_i = 0, rx_brk_i = 0;
    logic [6:0] line_ctrl_o;
    logic [15:0] divisor_o;
    logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
    logic dtr_o, rts_o, out1_o, out2_o;

    int n_tot = 0, n_bad = 0;
    bit done = 0;

    // Bench model of the register state, derived from the requirements.
    logic [7:0] m_lcr, m_dll, m_dlm, m_thr, m_rbr;
    logic [3:0] m_ier, m_err, m_lvl, m_dlt;
    logic [4:0] m_mcr;
    logic m_full, m_dr, m_threp;

    always #10 clk = ~clk;

    uart_regs_top dut_i (.*);

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] f_lvl_now();
        if (m_mcr[4]) return {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1]};
        return {dcd_i, ri_i, dsr_i, cts_i};
    endfunction

    function automatic logic [7:0] f_iir();
        if (m_ier[2] && (|m_err)) return 8'h06;
        if (m_ier[0] && m_dr)     return 8'h04;
        if (m_ier[1] && m_threp)  return 8'h02;
        if (m_ier[3] && (|m_dlt)) return 8'h00;
        return 8'h01;
    endfunction

    function automatic logic [7:0] f_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? m_dll : m_rbr;
            3'd1: return m_lcr[7] ? m_dlm : {4'h0, m_ier};
            3'd2: return f_iir();
            3'd3: return m_lcr;
            3'd4: return {3'b000, m_mcr};
            3'd5: return {1'b0, ~m_full & tx_idle_i, ~m_full, m_err, m_dr};
            3'd6: return {m_lvl, m_dlt};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string f_tag(input logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? "R3" : "R5";
            3'd1: return m_lcr[7] ? "R3" : "R2";
            3'd2: return "R6";
            3'd4: return "R8";
            3'd5: return "R5";
            3'd6: return "R9";
            default: return "R2";
        endcase
    endfunction

    // One clock: check outputs against the model, advance the model, cross the edge.
    task automatic cyc();
        logic [3:0] lv;
        logic [7:0] iv;
        logic hand, t_wr, r_rd;
        #1;
        if (rd_en) chk(rdata, f_rd(addr), f_tag(addr));
        chk(irq_o, m_mcr[3] & ~f_iir()[0], "R11");
        chk(tx_valid_o, m_full, "R4");
        if (m_full) chk(tx_data_o, m_thr, "R4");
        chk({dtr_o, rts_o, out1_o, out2_o},
            m_mcr[4] ? 4'b0 : {m_mcr[0], m_mcr[1], m_mcr[2], m_mcr[3]}, m_mcr[4] ? "R10" : "R8");
        chk(loopback_o, m_mcr[4], "R10");
        chk(divisor_o, {m_dlm, m_dll}, "R3");
        chk(line_ctrl_o, m_lcr[6:0], "R12");
        lv   = f_lvl_now();
        iv   = f_iir();
        hand = m_full & tx_ready_i;
        t_wr = wr_en && addr == 3'd0 && !m_lcr[7];
        r_rd = rd_en && addr == 3'd0 && !m_lcr[7];
        m_err = ((rd_en && addr == 3'd5) ? 4'h0 : m_err) |
                {rx_valid_i & rx_brk_i, rx_valid_i & rx_frm_err_i, rx_valid_i & rx_par_err_i,
                 rx_valid_i & m_dr & ~r_rd};
        if (rx_valid_i) begin m_dr = 1'b1; m_rbr = rx_data_i; end
        else if (r_rd) m_dr = 1'b0;
        if (t_wr) m_threp = 1'b0;
        else if (hand) m_threp = 1'b1;
        else if (rd_en && addr == 3'd2 && iv == 8'h02) m_threp = 1'b0;
        if (t_wr) begin m_full = 1'b1; m_thr = wdata; end
        else if (hand) m_full = 1'b0;
        m_dlt = ((rd_en && addr == 3'd6) ? 4'h0 : m_dlt) | (lv ^ m_lvl);
        m_lvl = lv;
        if (wr_en) begin
            case (addr)
                3'd0: if (m_lcr[7]) m_dll = wdata;
                3'd1: if (m_lcr[7]) m_dlm = wdata; else m_ier = wdata[3:0];
                3'd3: m_lcr = wdata;
                3'd4: m_mcr = wdata[4:0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        wr_en = 0; rd_en = 0; rx_valid_i = 0;
        rx_par_err_i = 0; rx_frm_err_i = 0; rx_brk_i = 0; tx_ready_i = 0;
    endtask

    task automatic idle(); clr(); cyc(); endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        clr(); addr = a; wdata = d; wr_en = 1; cyc(); clr();
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
        clr(); addr = a; rd_en = 1;
        #1 chk(rdata, e, tag);
        cyc(); clr();
    endtask

    task automatic rx_push(input logic [7:0] d, input logic pe);
        clr(); rx_valid_i = 1; rx_data_i = d; rx_par_err_i = pe; cyc(); clr();
    endtask

    task automatic do_reset();
        @(negedge clk);
        clr(); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_lcr = 0; m_dll = 0; m_dlm = 0; m_thr = 0; m_rbr = 0; m_ier = 0; m_err = 0;
        m_mcr = 0; m_full = 0; m_dr = 0; m_threp = 0; m_dlt = 0;
        m_lvl = {dcd_i, ri_i, dsr_i, cts_i};
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1995));
        cts_i = 1; dsr_i = 0; ri_i = 1; dcd_i = 0; tx_idle_i = 1;
        do_reset();
        // R1: reset state at the ports
        #1;
        chk(irq_o, 1'b0, "R1");
        chk(divisor_o, 16'h0000, "R1");
        rd_exp(3'd2, 8'h01, "R1");
        rd_exp(3'd5, 8'h60, "R1");
        rd_exp(3'd1, 8'h00, "R1");
        rd_exp(3'd3, 8'h00, "R1");
        rd_exp(3'd4, 8'h00, "R1");
        rd_exp(3'd6, 8'h50, "R1");
        rd_exp(3'd7, 8'h00, "R2");

        // Constrained random traffic checked by the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            int r;
            clr();
            r = $urandom % 16;
            addr = 3'($urandom);
            wdata = 8'($urandom);
            if (r < 5) wr_en = 1;
            else if (r < 10) rd_en = 1;
            if ($urandom % 6 == 0) begin
                rx_valid_i = 1; rx_data_i = 8'($urandom);
                rx_par_err_i = ($urandom % 4 == 0);
                rx_frm_err_i = ($urandom % 5 == 0);
                rx_brk_i = ($urandom % 7 == 0);
            end
            tx_ready_i = ($urandom % 3 == 0);
            tx_idle_i = ($urandom % 4 != 0);
            if ($urandom % 16 == 0) begin
                case ($urandom % 4)
                    0: cts_i = ~cts_i;
                    1: dsr_i = ~dsr_i;
                    2: ri_i = ~ri_i;
                    default: dcd_i = ~dcd_i;
                endcase
            end
            cyc();
        end

        // Directed corners from a clean state.
        cts_i = 0; dsr_i = 0; ri_i = 0; dcd_i = 0; tx_idle_i = 1;
        do_reset();
        // R3: bank bit remaps offsets 0/1 to divisor
        wr(3'd1, 8'hFF);
        rd_exp(3'd1, 8'h0F, "R2");
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        idle();
        chk(divisor_o, 16'h1234, "R3");
        chk(tx_valid_o, 1'b0, "R3");
        rd_exp(3'd0, 8'h34, "R3");
        rd_exp(3'd1, 8'h12, "R3");
        wr(3'd3, 8'h03);
        rd_exp(3'd1, 8'h0F, "R3");
        chk(line_ctrl_o, 7'h03, "R12");
        wr(3'd2, 8'hAA);
        rd_exp(3'd2, 8'h01, "R2");

        // R6/R7: stacked causes read out in priority order
        wr(3'd4, 8'h08);
        wr(3'd0, 8'h55);
        rd_exp(3'd5, 8'h00, "R4");
        clr(); tx_ready_i = 1; cyc(); clr();
        rd_exp(3'd2, 8'h02, "R7");
        rd_exp(3'd2, 8'h01, "R7");
        wr(3'd0, 8'h66);
        clr(); tx_ready_i = 1; cyc(); clr();
        wr(3'd0, 8'h77);
        rd_exp(3'd2, 8'h01, "R7");
        clr(); tx_ready_i = 1; cyc(); clr();
        cts_i = 1;
        idle();
        idle();
        rx_push(8'hA5, 1'b1);
        rd_exp(3'd2, 8'h06, "R6");
        rd_exp(3'd5, 8'h65, "R5");
        rd_exp(3'd2, 8'h04, "R6");
        rd_exp(3'd0, 8'hA5, "R5");
        rd_exp(3'd2, 8'h02, "R6");
        rd_exp(3'd2, 8'h00, "R6");
        rd_exp(3'd6, 8'h11, "R9");
        rd_exp(3'd2, 8'h01, "R6");
        #1 chk(irq_o, 1'b0, "R11");

        // R5: overrun on back-to-back receive
        rx_push(8'h01, 1'b0);
        rx_push(8'h02, 1'b0);
        rd_exp(3'd5, 8'h63, "R5");
        rd_exp(3'd5, 8'h61, "R5");
        rd_exp(3'd0, 8'h02, "R5");

        // R11: interrupt line gated by auxiliary output 2
        wr(3'd4, 8'h00);
        rx_push(8'h3C, 1'b0);
        idle();
        chk(irq_o, 1'b0, "R11");
        rd_exp(3'd2, 8'h04, "R11");
        wr(3'd4, 8'h08);
        #1 chk(irq_o, 1'b1, "R11");
        chk(out2_o, 1'b1, "R8");
        rd_exp(3'd0, 8'h3C, "R5");

        // R10: loopback routing
        cts_i = 0;
        idle();
        idle();
        rd_exp(3'd6, 8'h01, "R9");
        wr(3'd4, 8'h1F);
        idle();
        idle();
        chk({dtr_o, rts_o, out1_o, out2_o}, 4'b0000, "R10");
        chk(loopback_o, 1'b1, "R10");
        rd_exp(3'd6, 8'hFF, "R10");
        wr(3'd4, 8'h11);
        idle();
        idle();
        rd_exp(3'd6, 8'h2D, "R10");
        wr(3'd4, 8'h03);
        idle();
        chk({dtr_o, rts_o}, 2'b11, "R8");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule